// File: doc/BRIEF.md
# Processing-in-Memory Bank Access Router

This block routes memory commands to the bank models of one pseudo-channel whose banks each have a small processing unit beside them. It holds the channel's operating mode: single-bank, broadcast, or broadcast-with-compute. For every read or write strobe it produces that cycle's per-bank enables and write data. It also produces the compute-unit trigger strobes and the data returned to the host.

In single-bank mode a command reaches only the addressed bank. In broadcast mode the bank address is ignored. Every bank is enabled, so the host can load the same input-vector slice or microkernel into all units with one write.

In compute mode only the lowest bank-address bit is used. It picks the even or the odd bank of every pair. Row and column are forwarded to the triggered units. A read hands the fetched bank data to the units and not to the host. A write stores each unit's result into its own bank and drops the host's data.

Mode changes come on a separate request input. The states and transitions are:
- SINGLE ↔ BROADCAST.
- BROADCAST → COMPUTE.
- COMPUTE → SINGLE and COMPUTE → BROADCAST.
- A request for the current mode is a legal no-op.

SINGLE → COMPUTE and the unused code are refused.

Top module: `pim_bank_router`

## Requirements
- R1: After reset the mode is SINGLE (code 0), `mode_err` is low, and with `cmd_vld` low every bank enable, write enable and trigger is 0.
- R2: Mode codes are SINGLE=0, BROADCAST=1, COMPUTE=2. A legal request on `mode_req_vld` changes `mode` at the next rising edge. The legal requests are SINGLE↔BROADCAST, BROADCAST→COMPUTE, COMPUTE→SINGLE, COMPUTE→BROADCAST, and the current mode.
- R3: An illegal request (SINGLE→COMPUTE, or code 3) leaves `mode` unchanged. It raises `mode_err` for the one cycle after the request.
- R4: In SINGLE, a command enables only bank `cmd_bank`. A write asserts that bank's write enable with `host_wdata` on its lane. A read returns that bank's lane of `bank_rdata` on `host_rdata` with `host_rvld` high in the same cycle.
- R5: In BROADCAST, a write enables and writes every bank with `host_wdata`, whatever `cmd_bank` holds.
- R6: In BROADCAST, a read enables every bank and returns bank 0's lane on `host_rdata` with `host_rvld` high.
- R7: In COMPUTE, a command enables and triggers (`pu_trig`) exactly the banks whose index bit 0 equals `cmd_bank[0]`, in the same cycle. `pu_row`/`pu_col` carry `cmd_row`/`cmd_col`; they are zero whenever no trigger is raised.
- R8: In COMPUTE, a write drives each enabled bank's lane of `bank_wdata` with that bank's `pu_result` lane, ignoring `host_wdata`.
- R9: In COMPUTE, a read copies `bank_rdata` to `pu_rdata`. `host_rvld` stays low and `host_rdata` zero. `pu_rdata` is zero outside compute reads.
- R10: With `cmd_vld` low, all enables, write enables, triggers and `host_rvld` are 0, and lanes of `bank_wdata` for unwritten banks are 0.
- R11: A command in the same cycle as a mode request is routed under the mode held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe, one cycle |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | BANK_W | Bank address |
| cmd_row | input | ROW_W | Row address |
| cmd_col | input | COL_W | Column address |
| host_wdata | input | DATA_W | Write data from host |
| mode_req_vld | input | 1 | Mode-change request strobe |
| mode_req | input | 2 | Requested mode code |
| pu_result | input | NUM_BANKS*DATA_W | Compute-unit outputs, lane per bank |
| bank_rdata | input | NUM_BANKS*DATA_W | Bank read data, lane per bank |
| bank_en | output | NUM_BANKS | Per-bank access enable |
| bank_we | output | NUM_BANKS | Per-bank write enable |
| bank_wdata | output | NUM_BANKS*DATA_W | Per-bank write data |
| pu_trig | output | NUM_BANKS | Compute-unit trigger strobes |
| pu_row | output | ROW_W | Row forwarded to compute units |
| pu_col | output | COL_W | Column forwarded to compute units |
| pu_rdata | output | NUM_BANKS*DATA_W | Bank data forwarded to compute units |
| host_rdata | output | DATA_W | Read data to host |
| host_rvld | output | 1 | Host read data valid |
| mode | output | 2 | Current mode code |
| mode_err | output | 1 | Illegal request flag, one cycle |

## Verification
The bench drives commands and mode requests together at random. A wrong mode register shows on the very next command as the wrong set of bank enables. Typical symptoms are one bank instead of all, or all instead of half. It can also show as host data leaking where unit results belong, or as `host_rvld` toggling while computing. A lost or spurious refusal shows on `mode_err` and `mode` one cycle after the request. The bench therefore compares every output on every cycle against a mode model of its own.

// File: rtl/pim_router_pkg.sv
package pim_router_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_BCAST   = 2'd1,
        MODE_COMPUTE = 2'd2
    } pim_mode_t;
endpackage

// File: rtl/pim_mode_fsm.sv
module pim_mode_fsm
    import pim_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_vld,
    input  logic [1:0] req_code,
    output pim_mode_t  mode_q,
    output logic       err_q
);
    pim_mode_t mode_d;
    logic      refuse;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SINGLE;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            err_q  <= refuse;
        end
    end

    // transition decode
    always_comb begin
        mode_d = mode_q;
        refuse = 1'b0;
        if (req_vld) begin
            if (req_code == 2'd3) begin
                refuse = 1'b1;
            end else begin
                unique case (mode_q)
                    MODE_SINGLE: begin
                        if (req_code == 2'(MODE_COMPUTE)) refuse = 1'b1;
                        else mode_d = pim_mode_t'(req_code);
                    end
                    MODE_BCAST:   mode_d = pim_mode_t'(req_code);
                    MODE_COMPUTE: mode_d = pim_mode_t'(req_code);
                    default:      mode_d = MODE_SINGLE;
                endcase
            end
        end
    end

    AST_NO_SINGLE_TO_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SINGLE) |=> (mode_q != MODE_COMPUTE)); // R2
    AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (mode_q == $past(mode_q))); // R3
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != pim_mode_t'(2'd3))); // R2
endmodule

// File: rtl/pim_bank_lane.sv
module pim_bank_lane
    import pim_router_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int BANK_W = 4,
    parameter int DATA_W = 32
) (
    input  pim_mode_t           mode,
    input  logic                cmd_vld,
    input  logic                cmd_wr,
    input  logic [BANK_W-1:0]   cmd_bank,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [DATA_W-1:0]   pu_result,
    output logic                en,
    output logic                we,
    output logic                trig,
    output logic [DATA_W-1:0]   wdata
);
    localparam logic [BANK_W-1:0] MY_ADDR = BANK_W'(IDX);

    logic hit;

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            MODE_SINGLE:  hit = (cmd_bank == MY_ADDR);
            MODE_BCAST:   hit = 1'b1;
            MODE_COMPUTE: hit = (cmd_bank[0] == MY_ADDR[0]);
            default:      hit = 1'b0;
        endcase
        en    = cmd_vld & hit;
        we    = en & cmd_wr;
        trig  = en & (mode == MODE_COMPUTE);
        wdata = '0;
        if (we) wdata = (mode == MODE_COMPUTE) ? pu_result : host_wdata;
    end
endmodule

// File: rtl/pim_host_rmux.sv
module pim_host_rmux
    import pim_router_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int BANK_W    = 4,
    parameter int DATA_W    = 32
) (
    input  pim_mode_t                     mode,
    input  logic                          cmd_vld,
    input  logic                          cmd_wr,
    input  logic [BANK_W-1:0]             cmd_bank,
    input  logic [NUM_BANKS*DATA_W-1:0]   bank_rdata,
    output logic [DATA_W-1:0]             host_rdata,
    output logic                          host_rvld,
    output logic [NUM_BANKS*DATA_W-1:0]   pu_rdata
);
    logic rd;

    always_comb begin
        rd         = cmd_vld & ~cmd_wr;
        host_rdata = '0;
        host_rvld  = 1'b0;
        pu_rdata   = '0;
        unique case (mode)
            MODE_SINGLE: if (rd) begin
                host_rvld  = 1'b1;
                host_rdata = bank_rdata[int'(cmd_bank)*DATA_W +: DATA_W];
            end
            MODE_BCAST: if (rd) begin
                host_rvld  = 1'b1;
                host_rdata = bank_rdata[DATA_W-1:0];
            end
            MODE_COMPUTE: if (rd) pu_rdata = bank_rdata;
            default: ;
        endcase
    end
endmodule

// File: rtl/pim_bank_router.sv
module pim_bank_router
    import pim_router_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 6,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int BUS_W    = NUM_BANKS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_vld,
    input  logic               cmd_wr,
    input  logic [BANK_W-1:0]  cmd_bank,
    input  logic [ROW_W-1:0]   cmd_row,
    input  logic [COL_W-1:0]   cmd_col,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               mode_req_vld,
    input  logic [1:0]         mode_req,
    input  logic [BUS_W-1:0]   pu_result,
    input  logic [BUS_W-1:0]   bank_rdata,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic [BUS_W-1:0]   bank_wdata,
    output logic [NUM_BANKS-1:0] pu_trig,
    output logic [ROW_W-1:0]   pu_row,
    output logic [COL_W-1:0]   pu_col,
    output logic [BUS_W-1:0]   pu_rdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rvld,
    output logic [1:0]         mode,
    output logic               mode_err
);
    pim_mode_t cur_mode;

    pim_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (mode_req_vld),
        .req_code (mode_req),
        .mode_q   (cur_mode),
        .err_q    (mode_err)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        pim_bank_lane #(.IDX(b), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_lane (
            .mode       (cur_mode),
            .cmd_vld    (cmd_vld),
            .cmd_wr     (cmd_wr),
            .cmd_bank   (cmd_bank),
            .host_wdata (host_wdata),
            .pu_result  (pu_result[b*DATA_W +: DATA_W]),
            .en         (bank_en[b]),
            .we         (bank_we[b]),
            .trig       (pu_trig[b]),
            .wdata      (bank_wdata[b*DATA_W +: DATA_W])
        );
    end

    pim_host_rmux #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_rmux (
        .mode       (cur_mode),
        .cmd_vld    (cmd_vld),
        .cmd_wr     (cmd_wr),
        .cmd_bank   (cmd_bank),
        .bank_rdata (bank_rdata),
        .host_rdata (host_rdata),
        .host_rvld  (host_rvld),
        .pu_rdata   (pu_rdata)
    );

    // address forwarding to compute units
    always_comb begin
        mode   = 2'(cur_mode);
        pu_row = '0;
        pu_col = '0;
        if (|pu_trig) begin
            pu_row = cmd_row;
            pu_col = cmd_col;
        end
    end

    AST_SINGLE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SINGLE) |-> $onehot0(bank_en)); // R4
    AST_COMPUTE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cur_mode == MODE_COMPUTE) |-> ($countones(pu_trig) == NUM_BANKS/2)); // R7
    AST_TRIG_ONLY_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pu_trig) |-> (cur_mode == MODE_COMPUTE)); // R7
    AST_COMPUTE_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_COMPUTE) |-> !host_rvld); // R9
    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |-> (bank_en == '0 && !host_rvld)); // R10
endmodule

// File: tb/pim_bank_router_test.sv
module pim_bank_router_test;
    localparam int NB = 16;
    localparam int BW = 4;
    localparam int RW = 14;
    localparam int CW = 6;
    localparam int DW = 32;
    localparam int BUS = NB * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_vld = 0, cmd_wr = 0;
    logic [BW-1:0] cmd_bank = '0;
    logic [RW-1:0] cmd_row = '0;
    logic [CW-1:0] cmd_col = '0;
    logic [DW-1:0] host_wdata = '0;
    logic mode_req_vld = 0;
    logic [1:0] mode_req = '0;
    logic [BUS-1:0] pu_result = '0, bank_rdata = '0;
    logic [NB-1:0] bank_en, bank_we, pu_trig;
    logic [BUS-1:0] bank_wdata, pu_rdata;
    logic [RW-1:0] pu_row;
    logic [CW-1:0] pu_col;
    logic [DW-1:0] host_rdata;
    logic host_rvld;
    logic [1:0] mode;
    logic mode_err;

    int checks = 0;
    int fails = 0;
    logic [1:0] m_mode = 2'd0;
    logic m_err = 1'b0;

    always #4 clk = ~clk;

    pim_bank_router #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .host_wdata(host_wdata), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
        .pu_result(pu_result), .bank_rdata(bank_rdata), .bank_en(bank_en),
        .bank_we(bank_we), .bank_wdata(bank_wdata), .pu_trig(pu_trig),
        .pu_row(pu_row), .pu_col(pu_col), .pu_rdata(pu_rdata),
        .host_rdata(host_rdata), .host_rvld(host_rvld), .mode(mode), .mode_err(mode_err)
    );

    function automatic bit legal(input logic [1:0] cur, input logic [1:0] req);
        if (req == 2'd3) return 0;
        if (cur == 2'd0 && req == 2'd2) return 0;
        return 1;
    endfunction

    function automatic logic [NB-1:0] exp_en();
        logic [NB-1:0] e = '0;
        if (!cmd_vld) return e;
        for (int i = 0; i < NB; i++) begin
            if (m_mode == 2'd0) e[i] = (i == int'(cmd_bank));
            else if (m_mode == 2'd1) e[i] = 1'b1;
            else e[i] = ((i % 2) == int'(cmd_bank[0]));
        end
        return e;
    endfunction

    task automatic chk(input string req, input string what, input logic [BUS-1:0] act,
                       input logic [BUS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [NB-1:0] en, we, tr;
        logic [BUS-1:0] wd, prd;
        logic [DW-1:0] hrd;
        logic hv;
        string rq;
        en = exp_en();
        we = cmd_wr ? en : '0;
        tr = (m_mode == 2'd2) ? en : '0;
        wd = '0;
        for (int i = 0; i < NB; i++)
            if (we[i]) wd[i*DW +: DW] = (m_mode == 2'd2) ? pu_result[i*DW +: DW] : host_wdata;
        prd = (m_mode == 2'd2 && cmd_vld && !cmd_wr) ? bank_rdata : '0;
        hv  = cmd_vld && !cmd_wr && m_mode != 2'd2;
        hrd = '0;
        if (hv) hrd = (m_mode == 2'd0) ? bank_rdata[int'(cmd_bank)*DW +: DW] : bank_rdata[DW-1:0];
        if (!cmd_vld) rq = "R10";
        else if (m_mode == 2'd0) rq = "R4";
        else if (m_mode == 2'd1) rq = cmd_wr ? "R5" : "R6";
        else rq = cmd_wr ? "R8" : "R9";
        chk(rq, "bank_en", BUS'(bank_en), BUS'(en));
        chk(rq, "bank_we", BUS'(bank_we), BUS'(we));
        chk(rq, "bank_wdata", bank_wdata, wd);
        chk((m_mode == 2'd2) ? "R7" : rq, "pu_trig", BUS'(pu_trig), BUS'(tr));
        chk("R7", "pu_row", BUS'(pu_row), (|tr) ? BUS'(cmd_row) : '0);
        chk("R7", "pu_col", BUS'(pu_col), (|tr) ? BUS'(cmd_col) : '0);
        chk("R9", "pu_rdata", pu_rdata, prd);
        chk(rq, "host_rvld", BUS'(host_rvld), BUS'(hv));
        chk(rq, "host_rdata", BUS'(host_rdata), BUS'(hrd));
        chk("R2", "mode", BUS'(mode), BUS'(m_mode));
        chk("R3", "mode_err", BUS'(mode_err), BUS'(m_err));
    endtask

    // one cycle: drive at negedge, check before posedge, advance model at posedge
    task automatic step(input bit v, input bit w, input logic [BW-1:0] b,
                        input bit rv, input logic [1:0] rc);
        @(negedge clk);
        cmd_vld = v; cmd_wr = w; cmd_bank = b;
        cmd_row = RW'($urandom); cmd_col = CW'($urandom);
        host_wdata = $urandom;
        for (int i = 0; i < NB; i++) begin
            pu_result[i*DW +: DW] = $urandom;
            bank_rdata[i*DW +: DW] = $urandom;
        end
        mode_req_vld = rv; mode_req = rc;
        #1;
        check_outputs();   // R11: routing uses the mode held before the edge
        @(posedge clk);
        m_err = rv && !legal(m_mode, rc);
        if (rv && legal(m_mode, rc)) m_mode = rc;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk("R1", "mode", BUS'(mode), '0);
        chk("R1", "mode_err", BUS'(mode_err), '0);
        chk("R1", "bank_en", BUS'(bank_en), '0);
        chk("R1", "pu_trig", BUS'(pu_trig), '0);
        // R3: SINGLE -> COMPUTE refused, then code 3 refused
        step(0, 0, 0, 1, 2'd2);
        step(0, 0, 0, 1, 2'd3);
        step(1, 1, 4'd5, 0, 0);     // R4 single write
        step(1, 0, 4'd9, 1, 2'd1);  // R4 read + R11 with request
        step(1, 1, 4'd7, 0, 0);     // R5
        step(1, 0, 4'd3, 1, 2'd2);  // R6 then enter COMPUTE
        step(1, 1, 4'd3, 0, 0);     // R8 odd parity
        step(1, 0, 4'd6, 0, 0);     // R9 even parity
        step(1, 0, 4'd1, 1, 2'd0);  // R7 then back to SINGLE
        step(0, 0, 0, 0, 0);        // R10
        for (int k = 0; k < 3000; k++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, BW'($urandom),
                 $urandom_range(0, 3) == 0, 2'($urandom));
        step(0, 0, 0, 0, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule